// File: doc/BRIEF.md
# Latency-Timer Burst Controller

This controller sits inside a master on a shared, arbitrated bus and decides how long the master keeps the bus during a multi-dword burst. A one-cycle `start` pulse with a dword count requests the bus through an active-low request line. When the arbiter's active-low grant is sampled, the controller asserts an active-low frame on the next clock, loads a down-counter from the programmable latency-timer value, and lets that counter fall once per owned clock. Each data phase completes on a clock where the active-low target-ready is sampled low.

The timer does not end a burst by running out. The master keeps bursting while grant stays asserted. It shortens the burst only when the timer is at zero and grant has been taken away. The next data phase then becomes the final one, and the master leaves the bus once that phase completes. A burst that reaches its dword count first ends normally, whatever the timer holds. A one-cycle `done` pulse marks the end of every burst. `expired` shows whether the burst was cut short, and `xfer_cnt` gives the number of data phases completed.

The state machine has six states:

- IDLE: waits for `start`.
- ARB: request asserted, waiting for grant. IDLE goes to ARB on `start`.
- ADDR: the address clock, frame asserted. ARB goes to ADDR on grant.
- BURST: data phases that are not the last one.
- FINAL: the last data phase, with frame and request released. ADDR or BURST goes to FINAL on the count condition or the cut-short condition. Otherwise ADDR goes to BURST and BURST stays in BURST.
- DONE: the one-cycle end marker. FINAL goes to DONE on target-ready. DONE goes to IDLE unconditionally.

Top module: `burst_lat_ctrl`

## Requirements
- R1: During and directly after synchronous active-high reset, `req_n` and `frame_n` are 1, `done` and `expired` are 0, and `xfer_cnt` is 0.
- R2: A `start` pulse in IDLE makes `req_n` go to 0 on the next clock while `frame_n` stays 1. `start` in any other state is ignored and does not change the running burst's count.
- R3: `frame_n` goes to 0 in the clock after the one on which `gnt_n` is sampled 0 while requesting. It never falls without grant having been 0 on the previous clock.
- R4: On grant the timer is loaded with `lat_timer`. It then decrements once per owned clock (ADDR, BURST, FINAL) and saturates at 0.
- R5: While `gnt_n` stays 0, a burst is never shortened, even with `lat_timer` = 0. The burst completes all requested phases and `expired` stays 0.
- R6: If the timer is 0 and `gnt_n` is 1 at the address clock or at a completing data phase, the next data phase is the last one. With target-ready always asserted and grant removed right after it was given, the burst moves `lat_timer`+1 phases when the count is larger than that, and `expired` reads 1.
- R7: Reaching the requested count takes priority over a cut-short in the same clock. If the count equals `lat_timer`+1 with grant removed, all phases complete and `expired` is 0.
- R8: During the final data phase, both `frame_n` and `req_n` are 1. While `frame_n` is 0, `req_n` is 0. A data phase completes only on a clock with `trdy_n` = 0, so wait states stretch a phase without counting it.
- R9: `done` is 1 for exactly one clock, the clock after the final phase completes, with `frame_n` and `req_n` 1. At that point `xfer_cnt` equals the number of completed data phases.
- R10: A requested count of 0 is treated as 1, giving one data phase.
- R11: `expired` keeps its value after `done` until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a burst |
| n_dwords | input | CNT_W | Requested number of data phases, captured on `start` |
| lat_timer | input | LT_W | Latency-timer value loaded on grant |
| gnt_n | input | 1 | Bus grant, active low |
| trdy_n | input | 1 | Target ready, active low |
| req_n | output | 1 | Bus request, active low |
| frame_n | output | 1 | Frame, active low |
| xfer_cnt | output | CNT_W | Data phases completed in the current or last burst |
| done | output | 1 | One-cycle end-of-burst pulse |
| expired | output | 1 | Last burst was cut short by the timer |

## Verification
Normal completion by count and the timer-expiry cut-short can both trigger on the same completing phase. The bench provokes this by requesting exactly `lat_timer`+1 dwords and removing grant right after it is given. It judges the result by a full phase count with `expired` at 0. The bench also runs neighbouring counts on both sides of that point, which must either complete normally or be cut at `lat_timer`+1 phases with `expired` at 1.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARB   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_BURST = 3'd3,
        ST_FINAL = 3'd4,
        ST_DONE  = 3'd5
    } bstate_t;

endpackage

// File: rtl/lat_down_timer.sv
module lat_down_timer #(
    parameter int LT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            en,
    input  logic [LT_W-1:0] load_val,
    output logic            zero
);
    logic [LT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (en && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             inc,
    input  logic [CNT_W-1:0] n_in,
    output logic [CNT_W-1:0] count,
    output logic             one_phase,
    output logic             penult
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] n_eff;
    logic [EXT_W-1:0] cnt_plus2;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q   <= '0;
            cnt_q <= '0;
        end else if (cap) begin
            n_q   <= n_in;
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        n_eff     = (n_q == '0) ? EXT_W'(1) : {1'b0, n_q};
        cnt_plus2 = {1'b0, cnt_q} + EXT_W'(2);
    end

    assign count     = cnt_q;
    assign one_phase = (n_eff == EXT_W'(1));
    assign penult    = (cnt_plus2 == n_eff);
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_lat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic gnt_n,
    input  logic trdy_n,
    input  logic tzero,
    input  logic one_phase,
    input  logic penult,
    output logic req_n,
    output logic frame_n,
    output logic done,
    output logic expired,
    output logic cap,
    output logic tload,
    output logic ten,
    output logic inc
);
    bstate_t state, nxt;
    logic    cut;
    logic    expired_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // cut-short flag, cleared by an accepted start
    always_ff @(posedge clk) begin
        if (rst)
            expired_q <= 1'b0;
        else if (cap)
            expired_q <= 1'b0;
        else if (cut)
            expired_q <= 1'b1;
    end

    // next state
    always_comb begin
        nxt = state;
        cut = 1'b0;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ARB;
            ST_ARB:   if (!gnt_n) nxt = ST_ADDR;
            ST_ADDR: begin
                if (one_phase) begin
                    nxt = ST_FINAL;
                end else if (tzero && gnt_n) begin
                    nxt = ST_FINAL;
                    cut = 1'b1;
                end else begin
                    nxt = ST_BURST;
                end
            end
            ST_BURST: begin
                if (!trdy_n) begin
                    if (penult) begin
                        nxt = ST_FINAL;
                    end else if (tzero && gnt_n) begin
                        nxt = ST_FINAL;
                        cut = 1'b1;
                    end
                end
            end
            ST_FINAL: if (!trdy_n) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_n   = 1'b1;
        frame_n = 1'b1;
        done    = 1'b0;
        ten     = 1'b0;
        inc     = 1'b0;
        cap     = (state == ST_IDLE) && start;
        tload   = (state == ST_ARB) && !gnt_n;
        unique case (state)
            ST_IDLE:  ;
            ST_ARB:   req_n = 1'b0;
            ST_ADDR: begin
                req_n   = 1'b0;
                frame_n = 1'b0;
                ten     = 1'b1;
            end
            ST_BURST: begin
                req_n   = 1'b0;
                frame_n = 1'b0;
                ten     = 1'b1;
                inc     = !trdy_n;
            end
            ST_FINAL: begin
                ten = 1'b1;
                inc = !trdy_n;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign expired = expired_q;
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl #(
    parameter int LT_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] n_dwords,
    input  logic [LT_W-1:0]  lat_timer,
    input  logic             gnt_n,
    input  logic             trdy_n,
    output logic             req_n,
    output logic             frame_n,
    output logic [CNT_W-1:0] xfer_cnt,
    output logic             done,
    output logic             expired
);
    logic tzero, one_phase, penult;
    logic cap, tload, ten, inc;

    lat_down_timer #(.LT_W(LT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .en       (ten),
        .load_val (lat_timer),
        .zero     (tzero)
    );

    phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .inc       (inc),
        .n_in      (n_dwords),
        .count     (xfer_cnt),
        .one_phase (one_phase),
        .penult    (penult)
    );

    burst_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .gnt_n     (gnt_n),
        .trdy_n    (trdy_n),
        .tzero     (tzero),
        .one_phase (one_phase),
        .penult    (penult),
        .req_n     (req_n),
        .frame_n   (frame_n),
        .done      (done),
        .expired   (expired),
        .cap       (cap),
        .tload     (tload),
        .ten       (ten),
        .inc       (inc)
    );
endmodule

// File: rtl/burst_lat_chk.sv
module burst_lat_chk (
    input logic clk,
    input logic rst,
    input logic gnt_n,
    input logic req_n,
    input logic frame_n,
    input logic done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_n && frame_n && !done));

    // R3
    frame_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |-> $past(!gnt_n));

    // R8
    frame_holds_req_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> !req_n);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_n && req_n));

    // R8
    final_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> req_n);
endmodule

bind burst_lat_ctrl burst_lat_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .gnt_n   (gnt_n),
    .req_n   (req_n),
    .frame_n (frame_n),
    .done    (done)
);

// File: tb/sim_burst_lat_ctrl.sv
module sim_burst_lat_ctrl;
    localparam int CLK_PER = 10;
    localparam int LT_W    = 8;
    localparam int CNT_W   = 16;

    typedef struct {
        int unsigned phases;
        bit          cut;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] n_dwords = '0;
    logic [LT_W-1:0]  lat_timer = '0;
    logic             gnt_n = 1'b1;
    logic             trdy_n = 1'b1;
    logic             req_n, frame_n, done, expired;
    logic [CNT_W-1:0] xfer_cnt;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    always #(CLK_PER/2) clk = ~clk;

    burst_lat_ctrl #(.LT_W(LT_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .n_dwords(n_dwords),
        .lat_timer(lat_timer), .gnt_n(gnt_n), .trdy_n(trdy_n),
        .req_n(req_n), .frame_n(frame_n), .xfer_cnt(xfer_cnt),
        .done(done), .expired(expired)
    );

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: compare each end-of-burst against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(xfer_cnt == CNT_W'(e.phases), {e.tag, " phases"},
                    int'(xfer_cnt), int'(e.phases));
                chk(expired == e.cut, {e.tag, " expired"},
                    int'(expired), int'(e.cut));
            end
        end
    end

    // driver: one burst
    task automatic run_burst(int n, int t, bit drop, bit waits, bit poke, string tag);
        exp_t e;
        int   n_eff;
        int   cyc;
        n_eff    = (n == 0) ? 1 : n;
        e.cut    = drop && (n_eff > t + 1);
        e.phases = e.cut ? t + 1 : n_eff;
        e.tag    = tag;
        sb_q.push_back(e);

        @(negedge clk);
        start = 1'b1; n_dwords = CNT_W'(n); lat_timer = LT_W'(t);
        gnt_n = 1'b1; trdy_n = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: request up, frame still idle
        chk(req_n == 1'b0, "R2 req after start", int'(req_n), 0);
        chk(frame_n == 1'b1, "R3 no frame before grant", int'(frame_n), 1);
        @(negedge clk);
        chk(frame_n == 1'b1, "R3 no frame while waiting", int'(frame_n), 1);
        gnt_n = 1'b0;
        @(negedge clk);
        // R3: frame one clock after grant
        chk(frame_n == 1'b0, "R3 frame after grant", int'(frame_n), 0);
        if (drop) gnt_n = 1'b1;
        cyc = 0;
        while (done == 1'b0 && cyc < 400) begin
            trdy_n = waits ? cyc[0] : 1'b0;
            if (poke && cyc == 2) begin
                start = 1'b1; n_dwords = CNT_W'(1);
            end else begin
                start = 1'b0; n_dwords = CNT_W'(n);
            end
            if (frame_n == 1'b1)
                // R8: final phase releases request too
                chk(req_n == 1'b1, "R8 req released in final phase", int'(req_n), 1);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; trdy_n = 1'b1; gnt_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(req_n && frame_n, "R9 bus released", int'({req_n, frame_n}), 3);
        // R11: flag held after done
        chk(expired == e.cut, "R11 expired held", int'(expired), int'(e.cut));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1
        chk(req_n && frame_n, "R1 reset lines", int'({req_n, frame_n}), 3);
        chk(!done && !expired, "R1 reset flags", int'({done, expired}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(xfer_cnt == '0, "R1 count after reset", int'(xfer_cnt), 0);
        chk(req_n == 1'b1, "R1 idle after reset", int'(req_n), 1);

        run_burst(4, 200, 0, 0, 0, "R5 long timer");
        run_burst(6, 0, 0, 0, 0, "R5 zero timer grant held");
        run_burst(5, 1, 0, 1, 0, "R8 wait states");
        run_burst(10, 3, 1, 0, 0, "R6 cut at T+1");
        run_burst(9, 0, 1, 0, 0, "R6 cut T zero");
        run_burst(4, 3, 1, 0, 0, "R7 count equals T+1");
        run_burst(2, 1, 1, 0, 0, "R7 count equals T+1 small");
        run_burst(3, 6, 1, 0, 0, "R7 count below expiry");
        run_burst(8, 2, 0, 0, 1, "R2 start ignored while busy");
        run_burst(0, 5, 0, 0, 0, "R10 zero count");
        run_burst(12, 4, 1, 0, 0, "R4 timer reload");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R9 all bursts ended", sb_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule